// File: doc/BRIEF.md
# Banked Register Rotate Execution Unit

This block executes two single-word rotate instructions against a small byte-wide register file. An instruction word is accepted when the unit is idle. It then passes through four internal phases: decode, operand read, process and write. The decoder sees either a left rotate with no carry or a right rotate through the carry flag. It builds the full file address from the instruction's 8-bit offset and a bank number. The bank number comes either from the bank-select input or from the fixed access-bank mapping. The rotated byte goes to the working register or back into the file, and the flags are updated as each variant requires.

A load port and a combinational peek port give the surrounding logic a way to fill and inspect the register file. The bank-select width is a parameter. The file holds 2^BANK_BITS banks of 256 bytes, and the access bank's upper half maps onto the highest bank.

Top module: `rotx_unit`

## Requirements
- R1: Opcode bits [15:10] = 010001 selects rotate-left-no-carry: the result is {op[6:0], op[7]}.
- R2: Opcode bits [15:10] = 001100 selects rotate-right-through-carry: the result is {C, op[7:1]}, and C takes op[0].
- R3: Rotate-left-no-carry leaves the carry flag unchanged.
- R4: For both rotates, the negative flag equals result bit 7, and the zero flag is set exactly when the result is 0x00.
- R5: With bit 9 (d) = 0 the result is written to W and the file byte is unchanged. With d = 1 the result is written to the file byte and W is unchanged.
- R6: With bit 8 (a) = 0 the bank-select input is ignored. Offsets 0x00–0x7F address bank 0, and offsets 0x80–0xFF address the highest bank (all ones).
- R7: With a = 1 the address is {bankSel, offset}, where bankSel is sampled in the cycle the instruction is accepted.
- R8: An instruction is accepted on a clock edge with instrValid high while busy is low. busy is then high for four cycles, and done pulses for one cycle after them, with the results visible in that cycle. instrValid while busy is ignored.
- R9: Any other value of bits [15:10] changes neither W, the flags nor the file.
- R10: After reset W = 0x00, all flags are 0, and busy and done are low.
- R11: A load-port write stores loadData at loadAddr, and peekData shows the file byte at peekAddr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction offered this cycle |
| instrWord | input | 16 | Instruction word |
| bankSel | input | BANK_BITS | Bank-select register value |
| loadEn | input | 1 | File preload strobe |
| loadAddr | input | BANK_BITS+8 | File preload address |
| loadData | input | 8 | File preload data |
| peekAddr | input | BANK_BITS+8 | File inspection address |
| peekData | output | 8 | File byte at peekAddr |
| wReg | output | 8 | Working register |
| carryFlag | output | 1 | Carry flag |
| negFlag | output | 1 | Negative flag |
| zeroFlag | output | 1 | Zero flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is a right rotate that enters with carry set, because the carry can only be set by an earlier right rotate of an odd byte. Long random streams that mix both rotates over random file contents build such chains, and a bench model tracks the flags between instructions. A second difficult case is an access-bank operation on a high offset while bankSel points at a different bank. Random a bits and random nonzero bank values cover it, and the addressed byte is checked through the peek port.

// File: rtl/rotx_pkg.sv
package rotx_pkg;
  localparam logic [5:0] OPC_ROL  = 6'b010001;
  localparam logic [5:0] OPC_RORC = 6'b001100;

  typedef enum logic [2:0] {PH_IDLE, PH_Q1, PH_Q2, PH_Q3, PH_Q4} phase_t;

  typedef struct packed {
    logic grabOperand;
    logic grabResult;
    logic commit;
    logic isRight;
    logic isKnown;
    logic toFile;
  } strobe_t;
endpackage

// File: rtl/rotx_ctrl.sv
module rotx_ctrl
  import rotx_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int ADDR_W = BANK_BITS + 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  logic [15:0]          instrWord,
  input  logic [BANK_BITS-1:0] bankSel,
  output strobe_t              strobes,
  output logic [ADDR_W-1:0]    fileAddr,
  output logic                 busy,
  output logic                 done
);
  phase_t phase;
  logic [15:0] irReg;
  logic [BANK_BITS-1:0] bankReg;
  logic opRight, opKnown, toFile;
  logic [ADDR_W-1:0] addrReg, nextAddr;
  logic isRol, isRor;

  always_comb begin
    isRol = irReg[15:10] == OPC_ROL;
    isRor = irReg[15:10] == OPC_RORC;
    if (irReg[8]) nextAddr = {bankReg, irReg[7:0]};
    else          nextAddr = {{BANK_BITS{irReg[7]}}, irReg[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      done    <= 1'b0;
      irReg   <= '0;
      bankReg <= '0;
      opRight <= 1'b0;
      opKnown <= 1'b0;
      toFile  <= 1'b0;
      addrReg <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (instrValid) begin
          irReg   <= instrWord;
          bankReg <= bankSel;
          phase   <= PH_Q1;
        end
        PH_Q1: begin
          opKnown <= isRol | isRor;
          opRight <= isRor;
          toFile  <= irReg[9];
          addrReg <= nextAddr;
          phase   <= PH_Q2;
        end
        PH_Q2: phase <= PH_Q3;
        PH_Q3: phase <= PH_Q4;
        PH_Q4: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.grabOperand = phase == PH_Q2;
    strobes.grabResult  = phase == PH_Q3;
    strobes.commit      = phase == PH_Q4;
    strobes.isRight     = opRight;
    strobes.isKnown     = opKnown;
    strobes.toFile      = toFile;
    fileAddr            = addrReg;
    busy                = phase != PH_IDLE;
  end

  // R8: completion follows exactly four busy cycles
  p_done_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy, 1) && $past(busy, 4) && !$past(busy, 5) && !busy));

  // R8: phase strobes never overlap
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.grabOperand, strobes.grabResult, strobes.commit}));

  // R8: instruction latch stays put while busy
  p_ir_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(irReg));
endmodule

// File: rtl/rotx_dpath.sv
module rotx_dpath
  import rotx_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int ADDR_W = BANK_BITS + 8,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData,
  output logic [7:0]        wReg,
  output logic              carryFlag,
  output logic              negFlag,
  output logic              zeroFlag
);
  logic [7:0] fileMem [DEPTH];
  logic [7:0] operandReg, resultReg, rotated;
  logic carryNext, carryNextReg;
  logic writeFile;

  assign writeFile = strobes.commit && strobes.isKnown && strobes.toFile;
  assign peekData  = fileMem[peekAddr];

  always_ff @(posedge clk) begin
    if (writeFile)   fileMem[fileAddr] <= resultReg;
    else if (loadEn) fileMem[loadAddr] <= loadData;
  end

  always_comb begin
    if (strobes.isRight) begin
      rotated   = {carryFlag, operandReg[7:1]};
      carryNext = operandReg[0];
    end else begin
      rotated   = {operandReg[6:0], operandReg[7]};
      carryNext = carryFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operandReg   <= '0;
      resultReg    <= '0;
      carryNextReg <= 1'b0;
      wReg         <= '0;
      carryFlag    <= 1'b0;
      negFlag      <= 1'b0;
      zeroFlag     <= 1'b0;
    end else begin
      if (strobes.grabOperand) operandReg <= fileMem[fileAddr];
      if (strobes.grabResult) begin
        resultReg    <= rotated;
        carryNextReg <= carryNext;
      end
      if (strobes.commit && strobes.isKnown) begin
        if (!strobes.toFile) wReg <= resultReg;
        carryFlag <= carryNextReg;
        negFlag   <= resultReg[7];
        zeroFlag  <= resultReg == 8'h00;
      end
    end
  end

  // R3: left rotate never moves the carry
  p_carry_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.isRight) |=> $stable(carryFlag));

  // R4: flags agree with a result landing in W
  p_flags_match_w_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && strobes.isKnown && !strobes.toFile)
      |=> (negFlag == wReg[7] && zeroFlag == (wReg == 8'h00)));

  // R5: file destination leaves W alone
  p_w_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && strobes.toFile) |=> $stable(wReg));

  // R9: unknown opcode touches nothing
  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.isKnown)
      |=> ($stable(wReg) && $stable(carryFlag) && $stable(negFlag) && $stable(zeroFlag)));
endmodule

// File: rtl/rotx_unit.sv
module rotx_unit
  import rotx_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int ADDR_W = BANK_BITS + 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  logic [15:0]          instrWord,
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic                 loadEn,
  input  logic [ADDR_W-1:0]    loadAddr,
  input  logic [7:0]           loadData,
  input  logic [ADDR_W-1:0]    peekAddr,
  output logic [7:0]           peekData,
  output logic [7:0]           wReg,
  output logic                 carryFlag,
  output logic                 negFlag,
  output logic                 zeroFlag,
  output logic                 busy,
  output logic                 done
);
  strobe_t strobes;
  logic [ADDR_W-1:0] fileAddr;

  rotx_ctrl #(.BANK_BITS(BANK_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .bankSel(bankSel), .strobes(strobes), .fileAddr(fileAddr),
    .busy(busy), .done(done)
  );

  rotx_dpath #(.BANK_BITS(BANK_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fileAddr(fileAddr),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .peekAddr(peekAddr), .peekData(peekData), .wReg(wReg),
    .carryFlag(carryFlag), .negFlag(negFlag), .zeroFlag(zeroFlag)
  );
endmodule

// File: tb/tb_rotx_unit.sv
module tb_rotx_unit;
  localparam int BANK_BITS = 2;
  localparam int ADDR_W = BANK_BITS + 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [BANK_BITS-1:0] bankSel = '0;
  logic loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0, peekAddr = '0;
  logic [7:0] loadData = '0;
  logic [7:0] peekData, wReg;
  logic carryFlag, negFlag, zeroFlag, busy, done;

  always #10 clk = ~clk;

  rotx_unit #(.BANK_BITS(BANK_BITS)) dut (.*);

  int total = 0, fails = 0, cycles = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] mW = '0;
  logic mC = 1'b0, mN = 1'b0, mZ = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic logic [ADDR_W-1:0] addrOf(input logic [15:0] ins, input logic [BANK_BITS-1:0] bk);
    if (ins[8]) return {bk, ins[7:0]};
    return {{BANK_BITS{ins[7]}}, ins[7:0]};
  endfunction

  task automatic loadByte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
    model[a] = d;
  endtask

  task automatic runInstr(input logic [15:0] ins, input logic [BANK_BITS-1:0] bk);
    logic [ADDR_W-1:0] ad;
    logic [7:0] op, res;
    string tagOp, tagAd;
    int n;
    ad = addrOf(ins, bk);
    op = model[ad];
    tagOp = "R9";
    if (ins[15:10] == 6'b010001) begin
      res = {op[6:0], op[7]}; tagOp = "R1";
    end else if (ins[15:10] == 6'b001100) begin
      res = {mC, op[7:1]}; mC = op[0]; tagOp = "R2";
    end else res = 8'h00;
    if (tagOp != "R9") begin
      mN = res[7]; mZ = (res == 8'h00);
      if (ins[9]) model[ad] = res; else mW = res;
    end
    tagAd = ins[8] ? "R7" : "R6";
    @(negedge clk);
    instrValid = 1'b1; instrWord = ins; bankSel = bk;
    @(negedge clk);
    instrValid = 1'b0;
    bankSel = ~bk;
    n = 1;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk("R8 done latency", n, 5);
    chk({tagOp, " R5 W"}, wReg, mW);
    chk(tagOp == "R1" ? "R3 carry" : {tagOp, " carry"}, carryFlag, mC);
    chk({tagOp, " R4 flags"}, {negFlag, zeroFlag}, {mN, mZ});
    peekAddr = ad; #1;
    chk({tagAd, " R5 file byte"}, peekData, model[ad]);
  endtask

  initial begin
    logic [15:0] ins;
    logic [5:0] opc;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 W", wReg, 8'h00);
    chk("R10 flags", {carryFlag, negFlag, zeroFlag}, 3'b000);
    chk("R10 busy/done", {busy, done}, 2'b00);
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++) loadByte(i[ADDR_W-1:0], 8'($urandom));
    // R11: load and peek
    for (int i = 0; i < 8; i++) begin
      peekAddr = ADDR_W'($urandom); #1;
      chk("R11 peek", peekData, model[peekAddr]);
    end
    // Directed R2 example: right rotate, carry 0, into W
    loadByte(10'h020, 8'hE6);
    runInstr({6'b001100, 1'b0, 1'b0, 8'h20}, 2'd3);
    chk("R2 W example", wReg, 8'h73);
    chk("R2 carry example", carryFlag, 1'b0);
    // Directed R1 example: left rotate back into file
    loadByte(10'h041, 8'hAB);
    runInstr({6'b010001, 1'b1, 1'b0, 8'h41}, 2'd2);
    peekAddr = 10'h041; #1;
    chk("R1 file example", peekData, 8'h57);
    // R2: carry in set, R4 zero result
    loadByte(10'h105, 8'h01);
    runInstr({6'b001100, 1'b0, 1'b1, 8'h05}, 2'd1);
    chk("R2 carry out", carryFlag, 1'b1);
    loadByte(10'h105, 8'h00);
    runInstr({6'b001100, 1'b1, 1'b1, 8'h05}, 2'd1);
    peekAddr = 10'h105; #1;
    chk("R2 carry into bit7", peekData, 8'h80);
    loadByte(10'h3F0, 8'h00);
    runInstr({6'b010001, 1'b0, 1'b0, 8'hF0}, 2'd0);
    chk("R4 zero", zeroFlag, 1'b1);
    chk("R6 high access to top bank", wReg, 8'h00);
    // R9: unknown opcode
    runInstr({6'b111111, 1'b1, 1'b0, 8'h10}, 2'd1);
    // R8: offer during busy is ignored
    @(negedge clk);
    instrValid = 1'b1; instrWord = {6'b010001, 1'b0, 1'b0, 8'h10}; bankSel = '0;
    @(negedge clk);
    instrWord = {6'b001100, 1'b1, 1'b0, 8'h11};
    @(negedge clk);
    instrValid = 1'b0;
    mN = model[10'h010][6]; mZ = (model[10'h010] == 8'h00);
    mW = {model[10'h010][6:0], model[10'h010][7]};
    while (!done) @(negedge clk);
    chk("R8 first kept", wReg, mW);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 no second op", {busy, done}, 2'b00);
    end
    peekAddr = 10'h011; #1;
    chk("R8 ignored write", peekData, model[10'h011]);
    // Random stream
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom % 10;
      if (r < 5) opc = 6'b010001;
      else if (r < 9) opc = 6'b001100;
      else begin
        opc = 6'($urandom);
        if (opc == 6'b010001 || opc == 6'b001100) opc = 6'b000000;
      end
      ins = {opc, 1'($urandom), 1'($urandom), 8'($urandom)};
      runInstr(ins, BANK_BITS'($urandom));
    end
    summary();
  end
endmodule